// File: doc/BRIEF.md
# ECC Syndrome to DIMM Pin Locator

When memory reports an ECC error, this block turns the syndrome into a physical location. It takes the syndrome code, the byte offset of the failing access inside its 64-byte line, and the bank that matched the access. It answers with a DIMM index, a one-hot or group mask over the eight DIMMs behind the controller, and the bus pin number. A line travels over the bus as four beats of 144 bits each. The block first rebuilds the bit position of the flipped bit within those 576 bits. For that it remaps the syndrome piecewise and adds the offset of the beat the access sat in. The position is then used in two ways. Flipped end for end, it indexes 2-bit fields packed four to a byte in a DIMM-selector table. Unflipped, it indexes a pin table.

Two sets of tables are held, one for symmetric and one for asymmetric population. They are filled through a byte-wide write port, and a per-request flag picks the set. Queries use a valid/ready request and a valid/ready response. Each lookup spends one cycle on capture and one on table reads. A multi-bit error reports the whole group of four DIMMs for the bank. A request that cannot be located reports an unknown status.

Top module: `synloc_top`

## Requirements
- R1: After reset, `reqReady` is 1 (with no load in progress) and `rspValid` is 0.
- R2: A request is taken in a cycle where `reqValid` and `reqReady` are both 1. `rspValid` rises two clock edges after that acceptance edge. Only one query is in flight, so `reqReady` is 0 from acceptance until the response is taken. Status encoding: 0 = single-bit located, 1 = multi-bit group, 2 = unknown. The value 3 never appears.
- R3: While `rspValid` is 1 and `rspReady` is 0, the response stays valid and every response field holds its value.
- R4: In any cycle with `ldEn` at 1, `reqReady` is 0 and no request is taken.
- R5: The status is unknown when `reqBankHit` is 0 or the signed syndrome lies outside -1..144. An unknown response has dimm 0, mask 0 and pin 0.
- R6: Syndrome -1 returns status 1, with dimm equal to the group's first DIMM, a mask of four consecutive ones starting at that DIMM, and pin 0.
- R7: The syndrome s is remapped to r. For s < 128, r = s+16. For 128..143, r = s-137. For 144..146, r = s-143. For larger values, r = s-147. The beat q is `reqLineOff[5:4]`, and the position is p = (3-q)*144 + r. A located response gives pin = pin table [set][p].
- R8: Let f = 575-p. The selector is bit (3 - f mod 4)*2 of DIMM-table byte f/4; only that least significant bit of the 2-bit field is used. The reported dimm is the first DIMM plus the selector, and the mask has that single bit set.
- R9: The first DIMM is (`reqBankId` mod 2)*4.
- R10: `reqSymmetric` = 1 selects table set 0 and 0 selects set 1. All request inputs, this one included, are sampled at the acceptance edge only.
- R11: A syndrome in range whose position p comes out negative returns the unknown status.
- R12: A write with `ldEn` = 1 stores `ldData` at index `ldIdx` of the set given by `ldSet`. `ldTable` = 0 picks the DIMM table (indices 0..143) and 1 picks the pin table (indices 0..575).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldEn | input | 1 | Table write strobe |
| ldTable | input | 1 | 0 = DIMM selector table, 1 = pin table |
| ldSet | input | 1 | Table set written |
| ldIdx | input | 10 | Entry index |
| ldData | input | 8 | Entry value |
| reqValid | input | 1 | Query present |
| reqReady | output | 1 | Query can be taken |
| reqSyndrome | input | 9 | Signed syndrome code |
| reqLineOff | input | 6 | Byte offset of the access inside its line |
| reqBankHit | input | 1 | A bank matched the address |
| reqBankId | input | 4 | Identifier of the matched bank |
| reqSymmetric | input | 1 | Symmetric population flag (set select) |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response taken |
| rspStatus | output | 2 | 0 located, 1 group, 2 unknown |
| rspDimm | output | 3 | Located DIMM or first DIMM of the group |
| rspDimmMask | output | 8 | DIMMs implicated |
| rspPin | output | 8 | Bus pin number of a located error |

## Verification
A table write and a query request can land in the same cycle. The bench starts a query while the pin table of set 1 is still being loaded and holds `reqValid` through the remaining writes. The reference model expects `reqReady` low for every write cycle and takes the query only on the first cycle after loading ends. Its answer is then checked against the freshly written tables. Outside that case, a response can sit unaccepted while the requester already presents new request values. The per-cycle comparison checks that those values neither enter the design nor disturb the held response.

// File: rtl/synloc_pkg.sv
package synloc_pkg;
  parameter int SYN_W      = 9;
  parameter int BANK_W     = 4;
  parameter int NUM_GROUPS = 2;
  parameter int GRP_DIMMS  = 4;
  parameter int QW_BITS    = 144;
  parameter int BEATS      = 4;
  parameter int LINE_BYTES = 64;
  parameter int PIN_W      = 8;
  parameter int LD_W       = 8;

  localparam int LINE_BITS  = QW_BITS * BEATS;
  localparam int FLD_PER_B  = 4;
  localparam int DMAP_BYTES = LINE_BITS / FLD_PER_B;
  localparam int POS_W      = $clog2(LINE_BITS);
  localparam int DIDX_W     = POS_W - 2;
  localparam int NUM_DIMMS  = NUM_GROUPS * GRP_DIMMS;
  localparam int DIMM_W     = $clog2(NUM_DIMMS);
  localparam int GSEL_W     = $clog2(NUM_GROUPS);
  localparam int GDIMM_W    = $clog2(GRP_DIMMS);
  localparam int LOFF_W     = $clog2(LINE_BYTES);
  localparam int QSEL_W     = $clog2(BEATS);
  localparam int BEAT_BYTES = LINE_BYTES / BEATS;
  localparam int CALC_W     = POS_W + 2;
  localparam int NUM_SETS   = 2;

  typedef enum logic [1:0] {
    ST_SINGLE  = 2'd0,
    ST_MULTI   = 2'd1,
    ST_UNKNOWN = 2'd2
  } locStatus_e;

  typedef struct packed {
    logic capture;
    logic lookup;
  } ctrlStrobe_t;
endpackage

// File: rtl/synloc_ctrl.sv
module synloc_ctrl
  import synloc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        ldEn,
  input  logic        rspReady,
  output logic        reqReady,
  output logic        rspValid,
  output ctrlStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_RESP} state_e;
  state_e state;

  assign reqReady       = (state == S_IDLE) && !ldEn;
  assign rspValid       = (state == S_RESP);
  assign strobe.capture = reqValid && reqReady;
  assign strobe.lookup  = (state == S_LOOK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
    end else begin
      unique case (state)
        S_IDLE:  if (strobe.capture) state <= S_LOOK;
        S_LOOK:  state <= S_RESP;
        S_RESP:  if (rspReady) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/synloc_dpath.sv
module synloc_dpath
  import synloc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic                     ldEn,
  input  logic                     ldTable,
  input  logic                     ldSet,
  input  logic [POS_W-1:0]         ldIdx,
  input  logic [LD_W-1:0]          ldData,
  input  logic signed [SYN_W-1:0]  reqSyndrome,
  input  logic [LOFF_W-1:0]        reqLineOff,
  input  logic                     reqBankHit,
  input  logic [BANK_W-1:0]        reqBankId,
  input  logic                     reqSymmetric,
  output locStatus_e               rspStatus,
  output logic [DIMM_W-1:0]        rspDimm,
  output logic [NUM_DIMMS-1:0]     rspDimmMask,
  output logic [PIN_W-1:0]         rspPin
);
  localparam logic signed [CALC_W-1:0] SYN_LO   = CALC_W'(-1);
  localparam logic signed [CALC_W-1:0] SYN_HI   = CALC_W'(QW_BITS);
  localparam logic signed [CALC_W-1:0] EDGE_A   = CALC_W'(QW_BITS - 16);
  localparam logic signed [CALC_W-1:0] EDGE_B   = CALC_W'(QW_BITS);
  localparam logic signed [CALC_W-1:0] EDGE_C   = CALC_W'(QW_BITS + 3);
  localparam logic signed [CALC_W-1:0] ADD_A    = CALC_W'(16);
  localparam logic signed [CALC_W-1:0] SUB_B    = CALC_W'(QW_BITS - 7);
  localparam logic signed [CALC_W-1:0] SUB_C    = CALC_W'(QW_BITS - 1);
  localparam logic signed [CALC_W-1:0] SUB_D    = CALC_W'(QW_BITS + 3);
  localparam logic signed [CALC_W-1:0] ZERO_C   = '0;

  logic [LD_W-1:0]  dimmMap [NUM_SETS][DMAP_BYTES];
  logic [PIN_W-1:0] pinMap  [NUM_SETS][LINE_BITS];

  // request-side position arithmetic
  logic signed [CALC_W-1:0] synExt, remapped, beatBase, posCalc;
  logic [QSEL_W-1:0]        qwSel, qwRev;
  logic [GSEL_W-1:0]        grpSel;
  locStatus_e               classNext;

  always_comb begin
    synExt = {{(CALC_W-SYN_W){reqSyndrome[SYN_W-1]}}, reqSyndrome};
    if (synExt < EDGE_A)      remapped = synExt + ADD_A;
    else if (synExt < EDGE_B) remapped = synExt - SUB_B;
    else if (synExt < EDGE_C) remapped = synExt - SUB_C;
    else                      remapped = synExt - SUB_D;
    qwSel    = QSEL_W'(reqLineOff / LOFF_W'(BEAT_BYTES));
    qwRev    = QSEL_W'(BEATS - 1) - qwSel;
    beatBase = CALC_W'(32'(qwRev) * QW_BITS);
    posCalc  = beatBase + remapped;
    grpSel   = GSEL_W'(reqBankId % BANK_W'(NUM_GROUPS));
    if (!reqBankHit || synExt < SYN_LO || synExt > SYN_HI) classNext = ST_UNKNOWN;
    else if (synExt == SYN_LO)                             classNext = ST_MULTI;
    else if (posCalc < ZERO_C)                             classNext = ST_UNKNOWN;
    else                                                   classNext = ST_SINGLE;
  end

  // captured query
  locStatus_e          classQ;
  logic [POS_W-1:0]    posQ;
  logic [DIMM_W-1:0]   firstQ;
  logic                setQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      classQ <= ST_UNKNOWN;
      posQ   <= '0;
      firstQ <= '0;
      setQ   <= 1'b0;
    end else if (strobe.capture) begin
      classQ <= classNext;
      posQ   <= POS_W'(posCalc);
      firstQ <= {grpSel, GDIMM_W'(0)};
      setQ   <= !reqSymmetric;
    end
  end

  // table writes
  always_ff @(posedge clk) begin
    if (ldEn) begin
      if (!ldTable && ldIdx < POS_W'(DMAP_BYTES))
        dimmMap[ldSet][DIDX_W'(ldIdx)] <= ldData;
      if (ldTable && ldIdx < POS_W'(LINE_BITS))
        pinMap[ldSet][ldIdx] <= PIN_W'(ldData);
    end
  end

  // table reads
  logic [POS_W-1:0] flipPos;
  logic [LD_W-1:0]  dimmByteQ;
  logic [PIN_W-1:0] pinQ;
  logic [1:0]       fieldOffQ;

  assign flipPos = POS_W'(LINE_BITS - 1) - posQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dimmByteQ <= '0;
      pinQ      <= '0;
      fieldOffQ <= '0;
    end else if (strobe.lookup && classQ == ST_SINGLE) begin
      dimmByteQ <= dimmMap[setQ][flipPos[POS_W-1:2]];
      pinQ      <= pinMap[setQ][posQ];
      fieldOffQ <= flipPos[1:0];
    end
  end

  // response shaping
  logic fieldBit;
  always_comb begin
    fieldBit    = dimmByteQ[{2'd3 - fieldOffQ, 1'b0}];
    rspStatus   = classQ;
    rspDimm     = '0;
    rspDimmMask = '0;
    rspPin      = '0;
    unique case (classQ)
      ST_SINGLE: begin
        rspDimm     = firstQ + DIMM_W'(fieldBit);
        rspDimmMask = NUM_DIMMS'(1) << rspDimm;
        rspPin      = pinQ;
      end
      ST_MULTI: begin
        rspDimm     = firstQ;
        rspDimmMask = NUM_DIMMS'({GRP_DIMMS{1'b1}}) << firstQ;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/synloc_top.sv
module synloc_top
  import synloc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ldEn,
  input  logic                    ldTable,
  input  logic                    ldSet,
  input  logic [POS_W-1:0]        ldIdx,
  input  logic [LD_W-1:0]         ldData,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic signed [SYN_W-1:0] reqSyndrome,
  input  logic [LOFF_W-1:0]       reqLineOff,
  input  logic                    reqBankHit,
  input  logic [BANK_W-1:0]       reqBankId,
  input  logic                    reqSymmetric,
  output logic                    rspValid,
  input  logic                    rspReady,
  output logic [1:0]              rspStatus,
  output logic [DIMM_W-1:0]       rspDimm,
  output logic [NUM_DIMMS-1:0]    rspDimmMask,
  output logic [PIN_W-1:0]        rspPin
);
  ctrlStrobe_t strobe;
  locStatus_e  statusInt;

  synloc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ldEn     (ldEn),
    .rspReady (rspReady),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  synloc_dpath u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .ldEn         (ldEn),
    .ldTable      (ldTable),
    .ldSet        (ldSet),
    .ldIdx        (ldIdx),
    .ldData       (ldData),
    .reqSyndrome  (reqSyndrome),
    .reqLineOff   (reqLineOff),
    .reqBankHit   (reqBankHit),
    .reqBankId    (reqBankId),
    .reqSymmetric (reqSymmetric),
    .rspStatus    (statusInt),
    .rspDimm      (rspDimm),
    .rspDimmMask  (rspDimmMask),
    .rspPin       (rspPin)
  );

  assign rspStatus = statusInt;
endmodule

// File: rtl/synloc_chk.sv
module synloc_chk
  import synloc_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 ldEn,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic                 rspValid,
  input logic                 rspReady,
  input logic [1:0]           rspStatus,
  input logic [DIMM_W-1:0]    rspDimm,
  input logic [NUM_DIMMS-1:0] rspDimmMask,
  input logic [PIN_W-1:0]     rspPin
);
  a_r4_load_blocks_query: assert property (@(posedge clk) disable iff (!rstN)
    ldEn |-> !reqReady);

  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  a_r2_two_edge_latency: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!rspValid ##1 rspValid));

  a_r2_status_legal: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspStatus != 2'd3));

  a_r3_response_held: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspStatus) && $stable(rspDimm)
                                 && $stable(rspDimmMask) && $stable(rspPin)));

  a_r6_group_of_four: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == 2'd1) |-> ($countones(rspDimmMask) == 4 && rspPin == '0
                                         && rspDimmMask[rspDimm]));

  a_r8_single_dimm: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == 2'd0) |-> ($countones(rspDimmMask) == 1 && rspDimmMask[rspDimm]));

  a_r5_unknown_empty: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspStatus == 2'd2) |-> (rspDimmMask == '0 && rspPin == '0 && rspDimm == '0));
endmodule

bind synloc_top synloc_chk u_chk (.*);

// File: tb/synloc_top_tb.sv
module synloc_top_tb;
  import synloc_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic                    ldEn = 1'b0, ldTable = 1'b0, ldSet = 1'b0;
  logic [POS_W-1:0]        ldIdx = '0;
  logic [LD_W-1:0]         ldData = '0;
  logic                    reqValid = 1'b0;
  logic                    reqReady;
  logic signed [SYN_W-1:0] reqSyndrome = '0;
  logic [LOFF_W-1:0]       reqLineOff = '0;
  logic                    reqBankHit = 1'b0;
  logic [BANK_W-1:0]       reqBankId = '0;
  logic                    reqSymmetric = 1'b0;
  logic                    rspValid;
  logic                    rspReady = 1'b0;
  logic [1:0]              rspStatus;
  logic [DIMM_W-1:0]       rspDimm;
  logic [NUM_DIMMS-1:0]    rspDimmMask;
  logic [PIN_W-1:0]        rspPin;

  synloc_top u_dut (.*);

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;
  int refDimm [2][144];
  int refPin  [2][576];

  int mState = 0, acceptCnt = 0;
  int expSt, expDimm, expMask, expPin;
  string expTag = "R2", curTag = "R2";

  task automatic chk(string tag, string what, logic [31:0] act, int exp);
    nChecks++;
    if (act !== 32'(exp)) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function void predict(int syn, int off, int bank, bit hit, bit sym);
    int first, set, r, q, p, f, b, sel;
    first = (bank % 2) * 4;
    set   = sym ? 0 : 1;
    expSt = 2; expDimm = 0; expMask = 0; expPin = 0;
    if (!hit || syn < -1 || syn > 144) return;
    if (syn == -1) begin
      expSt = 1; expDimm = first; expMask = 15 << first;
      return;
    end
    if (syn < 128)      r = syn + 16;
    else if (syn < 144) r = syn - 137;
    else if (syn < 147) r = syn - 143;
    else                r = syn - 147;
    q = (off / 16) % 4;
    p = (3 - q) * 144 + r;
    if (p < 0) return;
    f   = 575 - p;
    b   = refDimm[set][f / 4];
    sel = (b >> ((3 - (f % 4)) * 2)) & 1;
    expSt = 0; expDimm = first + sel; expMask = 1 << expDimm; expPin = refPin[set][p];
  endfunction

  // reference model
  always @(posedge clk) begin
    if (!rstN) mState = 0;
    else case (mState)
      0: if (reqValid && !ldEn) begin
           predict(int'(reqSyndrome), int'(reqLineOff), int'(reqBankId), reqBankHit, reqSymmetric);
           expTag = curTag;
           mState = 1;
           acceptCnt++;
         end
      1: mState = 2;
      default: if (rspReady) mState = 0;
    endcase
  end

  // per-cycle comparison
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      chk(ldEn ? "R4" : "R2", "reqReady", 32'(reqReady), (mState == 0 && !ldEn) ? 1 : 0);
      chk("R2", "rspValid", 32'(rspValid), (mState == 2) ? 1 : 0);
      if (mState == 2) begin
        chk(expTag, "status", 32'(rspStatus), expSt);
        chk(expTag, "dimm", 32'(rspDimm), expDimm);
        chk(expTag, "mask", 32'(rspDimmMask), expMask);
        chk(expTag, "pin", 32'(rspPin), expPin);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic loadEntry(bit tbl, bit set, int idx, int val);
    @(negedge clk);
    ldEn = 1'b1; ldTable = tbl; ldSet = set; ldIdx = POS_W'(idx); ldData = LD_W'(val);
    if (!tbl) refDimm[set][idx] = val;
    else      refPin[set][idx] = val;
  endtask

  task automatic loadEnd();
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  task automatic query(string tag, int syn, int off, int bank, bit hit, bit sym, int hold);
    int c;
    @(negedge clk);
    curTag = tag;
    reqSyndrome = SYN_W'(syn); reqLineOff = LOFF_W'(off); reqBankId = BANK_W'(bank);
    reqBankHit = hit; reqSymmetric = sym; reqValid = 1'b1;
    c = acceptCnt;
    while (acceptCnt == c) @(negedge clk);
    reqValid = 1'b0;
    reqSymmetric = !sym; reqBankId = ~reqBankId; reqSyndrome = SYN_W'(syn + 3); reqLineOff = ~reqLineOff;
    while (!rspValid) @(negedge clk);
    repeat (hold) @(negedge clk);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "rspValid in reset", 32'(rspValid), 0);
    rstN = 1'b1;
    @(posedge clk); #2;
    chk("R1", "reqReady after reset", 32'(reqReady), 1);
    chk("R1", "rspValid after reset", 32'(rspValid), 0);

    // R12: fill both sets of both tables
    for (int i = 0; i < 144; i++) loadEntry(1'b0, 1'b0, i, (i * 37 + 5) % 256);
    for (int i = 0; i < 576; i++) loadEntry(1'b1, 1'b0, i, (i * 7 + 3) % 256);
    for (int i = 0; i < 144; i++) loadEntry(1'b0, 1'b1, i, (i * 53 + 91) % 256);
    fork
      begin
        for (int i = 0; i < 576; i++) loadEntry(1'b1, 1'b1, i, (i * 11 + 13) % 256);
        loadEnd();
      end
      begin
        repeat (20) @(negedge clk);
        query("R4", 5, 0, 0, 1'b1, 1'b1, 0);
      end
    join

    // R7: each remap piece and each beat
    query("R7", 0,   0,  0, 1'b1, 1'b1, 0);
    query("R7", 127, 16, 0, 1'b1, 1'b1, 0);
    query("R7", 128, 0,  0, 1'b1, 1'b0, 0);
    query("R7", 137, 48, 1, 1'b1, 1'b1, 0);
    query("R7", 143, 32, 0, 1'b1, 1'b0, 0);
    query("R7", 144, 63, 1, 1'b1, 1'b1, 0);
    // R9: group from bank identifier
    query("R9", 10, 16, 1, 1'b1, 1'b1, 0);
    query("R9", 10, 16, 2, 1'b1, 1'b1, 0);
    query("R9", -1, 0,  3, 1'b1, 1'b0, 0);
    // R10: set selection
    query("R10", 40, 32, 0, 1'b1, 1'b1, 0);
    query("R10", 40, 32, 0, 1'b1, 1'b0, 0);
    // R6: multi-bit groups
    query("R6", -1, 0,  0, 1'b1, 1'b1, 0);
    query("R6", -1, 48, 5, 1'b1, 1'b0, 0);
    // R5: out of range and no bank
    query("R5", -2,   0, 0, 1'b1, 1'b1, 0);
    query("R5", 145,  0, 0, 1'b1, 1'b1, 0);
    query("R5", 255, 16, 1, 1'b1, 1'b0, 0);
    query("R5", -256, 0, 0, 1'b1, 1'b1, 0);
    query("R5", 3,    0, 1, 1'b0, 1'b1, 0);
    // R11: negative position
    query("R11", 128, 48, 0, 1'b1, 1'b1, 0);
    query("R11", 136, 63, 1, 1'b1, 1'b0, 0);
    // R3: response held while unaccepted
    query("R3", 20, 32, 1, 1'b1, 1'b1, 6);
    query("R3", -1, 0,  0, 1'b1, 1'b1, 4);
    // R12: rewrite one pin entry (position 448 of set 0) and read it back
    loadEntry(1'b1, 1'b0, 448, 165);
    loadEnd();
    query("R12", 0, 0, 0, 1'b1, 1'b1, 0);
    // R8: sweep every located code across beats, groups and sets
    for (int s = 0; s <= 144; s++) query("R8", s, (s % 4) * 16 + (s % 7), s % 3, 1'b1, s[0], 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule